// File: doc/BRIEF.md
# Programmable Flag Offset Register Interface

This block keeps the two threshold offsets used by a FIFO's almost-empty and almost-full comparators. It also gives each comparator a qualifier that reports whether its offset can be trusted. The comparators and the storage array sit outside the block. The block only supplies the offset values and their validity.

A static mode input selects how the offsets are loaded. In serial mode, the two offsets form one chain, and a single data pin shifts that chain in one bit per write-clock edge. In parallel mode, whole words arrive on the offset data bus, and a write pointer steps between the almost-empty and almost-full registers. In parallel mode a read pointer, clocked by the read clock, can step through the same two registers and place each value on the read bus. A pause in any sequence resumes at the point where it stopped. A master reset loads default offsets and marks both offsets valid.

Top module: `flag_offset_regs`

## Requirements
- R1: While master reset is active and after it is released, both offsets equal the default of DEPTH/4, both qualifiers are 1 and the read bus is 0.
- R2: In serial mode, a write-clock edge with `ld_n`=0 and `sen_n`=0 stores `si` into the next chain bit. The chain is 2*OFS_W bits long. Chain bit k is bit k of the almost-empty offset for k < OFS_W, and bit k-OFS_W of the almost-full offset above that. The first bit goes to almost-empty bit 0 and the last bit goes to almost-full bit OFS_W-1.
- R3: In serial mode, an edge with `ld_n`=1 or `sen_n`=1 stores nothing. Shifting continues with the next chain bit once both are low again.
- R4: Once a serial chain has begun, both qualifiers go to 0 and stay 0 until the last chain bit is stored. A new chain after a complete one again needs every bit.
- R5: After the edge that stores the last chain bit, `paf_ok` becomes 1 after two more write-clock edges and `pae_ok` becomes 1 after two read-clock edges. Neither becomes 1 one edge earlier.
- R6: In parallel mode, each write-clock edge with `ld_n`=0 and `wen_n`=0 stores `ofs_d` into the register selected by the write pointer. The pointer visits almost-empty, then almost-full, then wraps. A pause resumes at the register that would have been written next.
- R7: No offset changes on an edge without the load condition of the current mode: in parallel mode `sen_n` has no effect, and in serial mode `wen_n` has no effect.
- R8: In parallel mode, each read-clock edge with `ld_n`=0 and `ren_n`=0 loads `q` with the zero-extended offset selected by the read pointer. The read pointer visits almost-empty, then almost-full, then wraps, and moves independently of the write pointer.
- R9: `q` keeps its value on every read-clock edge without a parallel read. Read strobes in serial mode are ignored.
- R10: A master reset returns both pointers to the almost-empty register, even in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| ser_mode | input | 1 | Static load mode: 1 = serial, 0 = parallel |
| ld_n | input | 1 | Offset access select, active low |
| wen_n | input | 1 | Parallel write enable, active low |
| sen_n | input | 1 | Serial shift enable, active low |
| si | input | 1 | Serial offset data |
| ofs_d | input | OFS_W | Parallel offset data |
| ren_n | input | 1 | Parallel read enable, active low |
| q | output | DATA_W | Read bus carrying the zero-extended offset |
| empty_ofs | output | OFS_W | Almost-empty offset |
| full_ofs | output | OFS_W | Almost-full offset |
| pae_ok | output | 1 | Almost-empty offset valid (read domain) |
| paf_ok | output | 1 | Almost-full offset valid (write domain) |

## Verification
Serial loading is exercised in three ways. A directed chain with only its first and last bits set shows whether the bit order or the register split is wrong. Random chains with random pauses show whether a paused edge was wrongly taken as a shift. A half-loaded chain that is later finished shows whether the qualifiers are withheld and then released with the two-edge latency in each clock domain. Parallel mode uses a random mix of writes, reads and non-qualifying strobes, which separates independent pointer wrapping from crosstalk between the pointers. A reset issued while both pointers point at the almost-full register shows whether the reset returns them to the almost-empty register.

// File: rtl/flag_offset_regs.sv
module flag_offset_regs #(
  parameter int DEPTH   = 32768,
  parameter int OFS_W   = 15,
  parameter int DATA_W  = 18,
  parameter int DEF_OFS = DEPTH / 4
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst_n,
  input  logic              ser_mode,
  input  logic              ld_n,
  input  logic              wen_n,
  input  logic              sen_n,
  input  logic              si,
  input  logic [OFS_W-1:0]  ofs_d,
  input  logic              ren_n,
  output logic [DATA_W-1:0] q,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs,
  output logic              pae_ok,
  output logic              paf_ok
);
  localparam int CHAIN = 2 * OFS_W;
  localparam int CNT_W = $clog2(CHAIN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN - 1);
  localparam logic [OFS_W-1:0] DEF  = OFS_W'(DEF_OFS);

  logic [CHAIN-1:0] chain;
  logic [CNT_W-1:0] bcnt;
  logic wptr, rptr;
  logic e_done, f_done, f_s1, e_s1;

  wire ser_go = ser_mode & ~ld_n & ~sen_n;
  wire par_wr = ~ser_mode & ~ld_n & ~wen_n;
  wire par_rd = ~ser_mode & ~ld_n & ~ren_n;

  assign empty_ofs = chain[OFS_W-1:0];
  assign full_ofs  = chain[CHAIN-1:OFS_W];

  always_ff @(posedge wclk or negedge mrst_n) begin
    if (!mrst_n) begin
      chain  <= {DEF, DEF};
      bcnt   <= '0;
      wptr   <= 1'b0;
      e_done <= 1'b1;
      f_done <= 1'b1;
    end else if (ser_go) begin
      chain[bcnt] <= si;
      if (bcnt == LAST) begin
        bcnt   <= '0;
        e_done <= 1'b1;
        f_done <= 1'b1;
      end else begin
        bcnt   <= bcnt + 1'b1;
        e_done <= 1'b0;
        f_done <= 1'b0;
      end
    end else if (par_wr) begin
      if (wptr) begin
        chain[CHAIN-1:OFS_W] <= ofs_d;
        f_done <= 1'b1;
      end else begin
        chain[OFS_W-1:0] <= ofs_d;
        e_done <= 1'b1;
      end
      wptr <= ~wptr;
    end
  end

  always_ff @(posedge wclk or negedge mrst_n) begin
    if (!mrst_n) begin
      f_s1   <= 1'b1;
      paf_ok <= 1'b1;
    end else begin
      f_s1   <= f_done;
      paf_ok <= f_s1;
    end
  end

  always_ff @(posedge rclk or negedge mrst_n) begin
    if (!mrst_n) begin
      e_s1   <= 1'b1;
      pae_ok <= 1'b1;
      q      <= '0;
      rptr   <= 1'b0;
    end else begin
      e_s1   <= e_done;
      pae_ok <= e_s1;
      if (par_rd) begin
        q    <= DATA_W'(rptr ? full_ofs : empty_ofs);
        rptr <= ~rptr;
      end
    end
  end

  p_ser_wrap_r2: assert property (@(posedge wclk) disable iff (!mrst_n)
    (ser_go && bcnt == LAST) |=> (bcnt == '0 && e_done && f_done));

  p_ser_pending_r4: assert property (@(posedge wclk) disable iff (!mrst_n)
    (bcnt != '0) |-> (!e_done && !f_done));

  p_paf_latency_r5: assert property (@(posedge wclk) disable iff (!mrst_n)
    $rose(paf_ok) |-> $past(f_done, 2));

  p_par_hold_r7: assert property (@(posedge wclk) disable iff (!mrst_n)
    (!ser_mode && (ld_n || wen_n)) |=> $stable(chain));

  p_rptr_step_r8: assert property (@(posedge rclk) disable iff (!mrst_n)
    par_rd |=> (rptr != $past(rptr)));

  p_q_hold_r9: assert property (@(posedge rclk) disable iff (!mrst_n)
    !par_rd |=> $stable(q));
endmodule

// File: tb/sim_flag_offset_regs.sv
module sim_flag_offset_regs;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 12;
  localparam int DEPTH  = 32768;
  localparam int OFS_W  = 15;
  localparam int DATA_W = 18;
  localparam int CHAIN  = 2 * OFS_W;
  localparam logic [OFS_W-1:0] DEF = OFS_W'(DEPTH / 4);

  logic wclk = 1'b0, rclk = 1'b0;
  logic mrst_n = 1'b0, ser_mode = 1'b0;
  logic ld_n = 1'b1, wen_n = 1'b1, sen_n = 1'b1, ren_n = 1'b1, si = 1'b0;
  logic [OFS_W-1:0] ofs_d = '0;
  logic [DATA_W-1:0] q;
  logic [OFS_W-1:0] empty_ofs, full_ofs;
  logic pae_ok, paf_ok;

  int errs = 0, checks = 0, wcnt = 0, rcnt = 0;
  bit finished = 0;
  logic [OFS_W-1:0] m_e, m_f;
  logic [DATA_W-1:0] m_q;
  bit m_wp, m_rp;

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;
  always @(posedge wclk) wcnt++;
  always @(posedge rclk) rcnt++;

  flag_offset_regs #(.DEPTH(DEPTH), .OFS_W(OFS_W), .DATA_W(DATA_W)) u0 (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .ser_mode(ser_mode), .ld_n(ld_n),
    .wen_n(wen_n), .sen_n(sen_n), .si(si), .ofs_d(ofs_d), .ren_n(ren_n), .q(q),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs), .pae_ok(pae_ok), .paf_ok(paf_ok));

  function automatic logic [DATA_W-1:0] ext(input logic [OFS_W-1:0] v);
    return DATA_W'(v);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    chk(req, 32'(empty_ofs), 32'(m_e));
    chk(req, 32'(full_ofs), 32'(m_f));
    chk(req, 32'(q), 32'(m_q));
  endtask

  task automatic do_reset(input logic mode);
    @(negedge wclk);
    mrst_n = 1'b0; ser_mode = mode;
    ld_n = 1'b1; wen_n = 1'b1; sen_n = 1'b1; ren_n = 1'b1;
    repeat (3) @(negedge wclk);
    chk("R1 reset empty", 32'(empty_ofs), 32'(DEF));
    mrst_n = 1'b1;
    m_e = DEF; m_f = DEF; m_q = '0; m_wp = 0; m_rp = 0;
    repeat (2) @(negedge wclk);
    chk_regs("R1 after reset");
    chk("R1 pae_ok", 32'(pae_ok), 1);
    chk("R1 paf_ok", 32'(paf_ok), 1);
  endtask

  task automatic pwr(input logic [OFS_W-1:0] v);
    @(negedge wclk); ld_n = 1'b0; wen_n = 1'b0; ofs_d = v;
    @(negedge wclk); ld_n = 1'b1; wen_n = 1'b1;
    if (m_wp) m_f = v; else m_e = v;
    m_wp = ~m_wp;
    chk_regs("R6 parallel write");
  endtask

  task automatic prd(input logic expect_read);
    @(negedge rclk); ld_n = 1'b0; ren_n = 1'b0;
    @(negedge rclk); ld_n = 1'b1; ren_n = 1'b1;
    if (expect_read) begin
      m_q = ext(m_rp ? m_f : m_e);
      m_rp = ~m_rp;
      chk_regs("R8 parallel read");
    end else chk_regs("R9 serial read ignored");
  endtask

  task automatic pnoise();
    int k = int'($urandom_range(0, 2));
    @(negedge wclk);
    ofs_d = OFS_W'($urandom);
    case (k)
      0: begin ld_n = 1'b0; sen_n = 1'b0; end
      1: begin ld_n = 1'b1; wen_n = 1'b0; ren_n = 1'b0; end
      default: begin ld_n = 1'b0; wen_n = 1'b1; end
    endcase
    @(negedge wclk); ld_n = 1'b1; wen_n = 1'b1; sen_n = 1'b1; ren_n = 1'b1;
    @(negedge wclk);
    chk_regs("R7 no-load strobe ignored");
  endtask

  task automatic spause();
    int n = int'($urandom_range(0, 2));
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      si = 1'($urandom); wen_n = 1'($urandom);
      if ($urandom_range(0, 1) == 0) begin ld_n = 1'b1; sen_n = 1'b0; end
      else begin ld_n = 1'b0; sen_n = 1'b1; end
    end
  endtask

  task automatic sbits(input logic [CHAIN-1:0] w, input int first, input int last);
    for (int i = first; i <= last; i++) begin
      spause();
      @(negedge wclk); ld_n = 1'b0; sen_n = 1'b0; wen_n = 1'b1; si = w[i];
      if (i == CHAIN - 1) begin
        int base, rbase;
        base = wcnt + 1;
        @(posedge wclk); rbase = rcnt;
        fork
          begin
            @(negedge wclk); sen_n = 1'b1; ld_n = 1'b1;
            wait (wcnt == base + 1); #1;
            chk("R5 paf_ok one edge early", 32'(paf_ok), 0);
            wait (wcnt == base + 2); #1;
            chk("R5 paf_ok after two edges", 32'(paf_ok), 1);
          end
          begin
            wait (rcnt == rbase + 1); #1;
            chk("R5 pae_ok one edge early", 32'(pae_ok), 0);
            wait (rcnt == rbase + 2); #1;
            chk("R5 pae_ok after two edges", 32'(pae_ok), 1);
          end
        join
      end else begin
        @(negedge wclk); sen_n = 1'b1;
      end
    end
    ld_n = 1'b1; sen_n = 1'b1; wen_n = 1'b1;
  endtask

  task automatic schain_check(input logic [CHAIN-1:0] w, input string req);
    @(negedge wclk);
    chk(req, 32'(empty_ofs), 32'(w[OFS_W-1:0]));
    chk(req, 32'(full_ofs), 32'(w[CHAIN-1:OFS_W]));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [CHAIN-1:0] w;
    void'($urandom(32'd20240611));
    do_reset(1'b0);
    pwr(15'h0123); prd(1'b1); pwr(15'h7ABC); prd(1'b1); pwr(15'h0042); prd(1'b1);
    for (int i = 0; i < 60; i++) begin
      case ($urandom_range(0, 3))
        0: pwr(OFS_W'($urandom));
        1: prd(1'b1);
        2: pnoise();
        default: begin repeat (2) @(negedge rclk); chk_regs("R9 q holds when idle"); end
      endcase
    end
    do_reset(1'b0);
    pwr(15'h1111); prd(1'b1);
    do_reset(1'b0);
    pwr(15'h2222);
    chk("R10 write pointer back to empty", 32'(empty_ofs), 32'h2222);
    chk("R10 full untouched", 32'(full_ofs), 32'(DEF));
    prd(1'b1);
    chk("R10 read pointer back to empty", 32'(q), 32'h2222);

    do_reset(1'b1);
    prd(1'b0); prd(1'b0);
    w = {1'b1, 28'h0, 1'b1};
    sbits(w, 0, 9);
    repeat (3) @(negedge rclk);
    chk("R4 pae_ok withheld mid-chain", 32'(pae_ok), 0);
    chk("R4 paf_ok withheld mid-chain", 32'(paf_ok), 0);
    @(negedge wclk); ld_n = 1'b0; sen_n = 1'b1;
    repeat (4) begin @(negedge wclk); si = ~si; end
    ld_n = 1'b1; sen_n = 1'b0;
    repeat (3) begin @(negedge wclk); si = ~si; end
    ld_n = 1'b1; sen_n = 1'b1;
    sbits(w, 10, CHAIN - 1);
    schain_check(w, "R2 R3 directed chain order");
    for (int n = 0; n < 3; n++) begin
      w = CHAIN'({$urandom, $urandom});
      sbits(w, 0, 12);
      repeat (3) @(negedge rclk);
      chk("R4 reprogram withholds pae_ok", 32'(pae_ok), 0);
      chk("R4 reprogram withholds paf_ok", 32'(paf_ok), 0);
      sbits(w, 13, CHAIN - 1);
      schain_check(w, "R2 R3 random chain with pauses");
    end
    chk("R9 q unchanged in serial mode", 32'(q), 0);
    summary();
  end
endmodule